// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer

This block is a programmable timer built around one counter and one bidirectional pin. The counter serves three pin modes. In PWM mode the pin is an output that is high for a programmed number of ticks out of each period. In capture mode the pin is an input, and the block records both the high time and the full cycle time of the incoming waveform, which is enough for software to work out a serial baud rate. In event-count mode the pin is an input, and its rising edges drive the counter.

In PWM and capture modes the counter advances on a selectable tick. The tick is every system clock cycle, or a rising edge seen on one of two external clock inputs. Every asynchronous input passes through a two-flop synchronizer and is edge-detected in the system clock domain. The timer raises a one-cycle interrupt pulse at each period wrap in PWM or event-count mode, and at each new period measurement in capture mode. A sticky error flag records a capture counter that ran out of range before an edge arrived.

Top module: `gp_timer`

## Requirements
- R1: After reset, `count`, `pin_out`, `pin_oe`, `irq`, `ovf_err`, `cap_period` and `cap_width` are all zero.
- R2: With `cfg_mode`=0 (PWM) and enabled, each tick moves `count` one step through 0..P-1, where P = `cfg_period`, and wraps to 0 when the next value would reach P. A P of 0 or 1 wraps on every tick. `pin_out` is high exactly while `count` < `cfg_width`, so it is high for min(W,P) ticks in each period. `pin_oe` is 1.
- R3: `irq` is a single-cycle pulse, raised on every wrap in PWM or event-count mode.
- R4: `cfg_clksel` picks the tick: 0 = every system clock cycle, 1 = a rising edge on `ext_clk_a`, 2 = a rising edge on `ext_clk_b`, 3 = no tick. Edges on an input that is not selected have no effect on `count`.
- R5: With `cfg_mode`=2 (event count), each synchronized rising edge of `pin_in` is one tick, with the same wrap and `irq` as R2. `cfg_clksel` is ignored and `pin_oe` is 0.
- R6: With `cfg_mode`=1 (capture), the first rising edge of `pin_in` after enable only restarts the count. Each later rising edge loads `cap_period` with the number of ticks since the previous rising edge, restarts the count, and pulses `irq`. Each falling edge after an armed rising edge loads `cap_width` with the ticks since that rising edge.
- R7: In capture mode, a tick that arrives with `count` at its all-ones maximum leaves `count` saturated and sets `ovf_err`. `ovf_err` stays set while the timer remains enabled.
- R8: When `cfg_en` is 0 or `cfg_mode` is 3, the next clock edge forces `count`, `pin_out`, `pin_oe`, `irq` and `ovf_err` to 0. `cap_period` and `cap_width` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Timer enable |
| cfg_mode | input | 2 | 0 PWM, 1 capture, 2 event count, 3 idle |
| cfg_clksel | input | 2 | Tick source: 0 system, 1 ext A, 2 ext B, 3 none |
| cfg_period | input | CNT_W | Period in ticks |
| cfg_width | input | CNT_W | High time in ticks (PWM) |
| pin_in | input | 1 | Pin level as seen from the pad |
| ext_clk_a | input | 1 | External clock input A |
| ext_clk_b | input | 1 | External clock input B |
| pin_out | output | 1 | PWM output level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt pulse |
| count | output | CNT_W | Current counter value |
| cap_period | output | CNT_W | Last measured period in ticks |
| cap_width | output | CNT_W | Last measured high time in ticks |
| ovf_err | output | 1 | Capture overflow status (sticky) |

## Verification
The bench aims at the extremes of the PWM duty cycle: width 0, width equal to the period, width above the period, and a period of 1. A wrong compare there shows up as a glitch, or as an output that never goes high or never goes low. In capture mode it checks that the first edge after enable produces no bogus measurement, and that the period and width counts are exact; an off-by-one register shows up as a value one tick short. It also drives edges on the clock input that is not selected, and on any input while the tick source is "none", to catch a multiplexer that lets them leak into the count. It lets the counter saturate, which a design without saturation would show as a wrap to zero. Finally it confirms that disabling the timer clears the error flag and the pin but leaves the captured values intact.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_EVT  = 2'd2,
    MODE_IDLE = 2'd3
  } gpt_mode_e;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_EXTA = 2'd1,
    SRC_EXTB = 2'd2,
    SRC_NONE = 2'd3
  } gpt_src_e;

  // index of each synchronized input in the edge vector
  localparam int IDX_PIN  = 0;
  localparam int IDX_NPIN = 1;
  localparam int IDX_EXTA = 2;
  localparam int IDX_EXTB = 3;
  localparam int N_SYNC   = 4;
endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[LEN-2:0], din};
  end

  // newest synchronized sample high, previous one low
  assign rise = pipe[LEN-2] & ~pipe[LEN-1];
endmodule

// File: rtl/gpt_tick_sel.sv
module gpt_tick_sel
  import gpt_pkg::*;
(
  input  gpt_mode_e mode,
  input  gpt_src_e  src,
  input  logic      a_rise,
  input  logic      b_rise,
  input  logic      pin_rise,
  output logic      tick
);
  always_comb begin
    if (mode == MODE_EVT) begin
      tick = pin_rise;
    end else begin
      unique case (src)
        SRC_SYS:  tick = 1'b1;
        SRC_EXTA: tick = a_rise;
        SRC_EXTB: tick = b_rise;
        default:  tick = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  gpt_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  input  logic             tick,
  input  logic             pin_rise,
  input  logic             pin_fall,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_period,
  output logic [CNT_W-1:0] cap_width,
  output logic             ovf_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   ONE_W   = {{CNT_W{1'b0}}, 1'b1};

  logic             run;
  logic             armed;
  logic             wrap;
  logic             at_max;
  logic [CNT_W:0]   inc_w;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] ticks_so_far;

  assign run          = en && (mode != MODE_IDLE);
  assign inc_w        = {1'b0, count} + ONE_W;
  assign wrap         = inc_w >= {1'b0, period};
  assign at_max       = (count == CNT_MAX);
  assign cnt_next     = !tick ? count : (wrap ? '0 : inc_w[CNT_W-1:0]);
  assign ticks_so_far = (tick && !at_max) ? inc_w[CNT_W-1:0] : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      pin_out    <= 1'b0;
      pin_oe     <= 1'b0;
      irq        <= 1'b0;
      armed      <= 1'b0;
      ovf_err    <= 1'b0;
      cap_period <= '0;
      cap_width  <= '0;
    end else if (!run) begin
      count   <= '0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
      irq     <= 1'b0;
      armed   <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      irq    <= 1'b0;
      pin_oe <= (mode == MODE_PWM);
      if (mode == MODE_CAP) begin
        pin_out <= 1'b0;
        if (pin_rise) begin
          if (armed) begin
            cap_period <= ticks_so_far;
            irq        <= 1'b1;
          end
          armed <= 1'b1;
          count <= '0;
        end else begin
          if (pin_fall && armed) cap_width <= ticks_so_far;
          if (tick) begin
            if (at_max) ovf_err <= 1'b1;
            else        count   <= inc_w[CNT_W-1:0];
          end
        end
      end else begin
        count   <= cnt_next;
        pin_out <= (mode == MODE_PWM) && (cnt_next < width);
        if (tick && wrap) irq <= 1'b1;
      end
    end
  end

  // R8: a stopped timer never drives the pin high
  assert_out_low_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pin_out);

  // R3: an interrupt raised while driving PWM coincides with the wrap to zero
  assert_irq_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (irq && pin_oe) |-> (count == '0));

  // R7: the overflow status holds while the timer stays enabled
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && en && mode != MODE_IDLE) |=> ovf_err);

  // R2: between restarts the counter only moves upward
  assert_count_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> (count == '0) || (count >= $past(count)));
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_clksel,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             pin_in,
  input  logic             ext_clk_a,
  input  logic             ext_clk_b,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_period,
  output logic [CNT_W-1:0] cap_width,
  output logic             ovf_err
);
  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] rise_v;
  logic              tick;
  gpt_mode_e         mode;
  gpt_src_e          src;

  assign mode = gpt_mode_e'(cfg_mode);
  assign src  = gpt_src_e'(cfg_clksel);

  // a falling pin edge is detected as a rising edge of the inverted pin
  always_comb begin
    raw_in           = '0;
    raw_in[IDX_PIN]  = pin_in;
    raw_in[IDX_NPIN] = ~pin_in;
    raw_in[IDX_EXTA] = ext_clk_a;
    raw_in[IDX_EXTB] = ext_clk_b;
  end

  for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
    gpt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[gi]),
      .rise (rise_v[gi])
    );
  end

  gpt_tick_sel u_tick (
    .mode     (mode),
    .src      (src),
    .a_rise   (rise_v[IDX_EXTA]),
    .b_rise   (rise_v[IDX_EXTB]),
    .pin_rise (rise_v[IDX_PIN]),
    .tick     (tick)
  );

  gpt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .mode       (mode),
    .period     (cfg_period),
    .width      (cfg_width),
    .tick       (tick),
    .pin_rise   (rise_v[IDX_PIN]),
    .pin_fall   (rise_v[IDX_NPIN]),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .count      (count),
    .cap_period (cap_period),
    .cap_width  (cap_width),
    .ovf_err    (ovf_err)
  );
endmodule

// File: tb/gp_timer_tb.sv
module gp_timer_tb;
  localparam int W = 8;
  localparam int NV = 6;
  // PWM vectors: period, width, expected high ticks per period
  localparam int VP[NV] = '{5, 8, 4, 6, 1, 7};
  localparam int VW[NV] = '{2, 0, 4, 9, 1, 3};
  localparam int VH[NV] = '{2, 0, 4, 6, 1, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [1:0] cfg_clksel = 2'd0;
  logic [W-1:0] cfg_period = '0;
  logic [W-1:0] cfg_width = '0;
  logic pin_in = 1'b0, ext_clk_a = 1'b0, ext_clk_b = 1'b0;
  logic pin_out, pin_oe, irq, ovf_err;
  logic [W-1:0] count, cap_period, cap_width;

  int checks = 0, failures = 0;
  int irq_seen = 0, high_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gp_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_clksel(cfg_clksel), .cfg_period(cfg_period), .cfg_width(cfg_width),
    .pin_in(pin_in), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .count(count),
    .cap_period(cap_period), .cap_width(cap_width), .ovf_err(ovf_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq_seen  += int'(irq);
      high_seen += int'(pin_out);
    end
  endtask

  // which: 0 pin, 1 ext A, 2 ext B
  task automatic pulse(input int which, input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      case (which)
        0: pin_in = 1'b1;
        1: ext_clk_a = 1'b1;
        default: ext_clk_b = 1'b1;
      endcase
      step(hi);
      case (which)
        0: pin_in = 1'b0;
        1: ext_clk_a = 1'b0;
        default: ext_clk_b = 1'b0;
      endcase
      step(lo);
    end
  endtask

  task automatic start(input int mode, input int src, input int per, input int wid);
    cfg_en = 1'b0;
    step(2);
    cfg_mode = 2'(mode);
    cfg_clksel = 2'(src);
    cfg_period = W'(per);
    cfg_width = W'(wid);
    cfg_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R1: reset state
    check(count == 0 && cap_period == 0 && cap_width == 0, "R1 counters", int'(count), 0);
    check(!pin_out && !pin_oe && !irq && !ovf_err, "R1 flags",
          int'({pin_out, pin_oe, irq, ovf_err}), 0);

    // R2/R3: PWM vector table, two full periods measured in steady state
    for (int v = 0; v < NV; v++) begin
      start(0, 0, VP[v], VW[v]);
      step(2 * VP[v] + 6);
      irq_seen = 0;
      high_seen = 0;
      step(2 * VP[v]);
      check(high_seen == 2 * VH[v], "R2 pwm high ticks", high_seen, 2 * VH[v]);
      check(irq_seen == 2, "R3 irq per wrap", irq_seen, 2);
      check(pin_oe == 1'b1, "R2 pin_oe in pwm", int'(pin_oe), 1);
    end

    // R4: tick source select
    start(0, 1, 200, 0);
    step(1);
    pulse(1, 7, 2, 2);
    step(5);
    check(count == 7, "R4 ext A ticks", int'(count), 7);
    pulse(2, 5, 2, 2);
    step(5);
    check(count == 7, "R4 unselected ext B ignored", int'(count), 7);
    cfg_clksel = 2'd2;
    pulse(2, 3, 2, 2);
    step(5);
    check(count == 10, "R4 ext B ticks", int'(count), 10);
    cfg_clksel = 2'd3;
    pulse(1, 2, 2, 2);
    pulse(2, 2, 2, 2);
    step(5);
    check(count == 10, "R4 no tick source", int'(count), 10);

    // R5: event count with wrap at 4
    start(2, 0, 4, 0);
    step(1);
    irq_seen = 0;
    pulse(0, 6, 2, 2);
    step(5);
    check(count == 2, "R5 event count", int'(count), 2);
    check(irq_seen == 1, "R5 event wrap irq", irq_seen, 1);
    check(pin_oe == 1'b0, "R5 pin is input", int'(pin_oe), 0);

    // R6: capture, first rise only arms
    start(1, 0, 0, 0);
    step(5);
    irq_seen = 0;
    pin_in = 1'b1; step(6);
    pin_in = 1'b0; step(9);
    check(irq_seen == 0, "R6 first rise no measurement", irq_seen, 0);
    pin_in = 1'b1; step(5);
    check(cap_period == 15, "R6 period", int'(cap_period), 15);
    check(cap_width == 6, "R6 width", int'(cap_width), 6);
    check(irq_seen == 1, "R6 capture irq", irq_seen, 1);
    step(5);
    pin_in = 1'b0; step(2);
    pin_in = 1'b1; step(5);
    check(cap_period == 12, "R6 period second", int'(cap_period), 12);
    check(cap_width == 10, "R6 width second", int'(cap_width), 10);

    // R7: overflow with no edges
    cfg_en = 1'b0;
    pin_in = 1'b0;
    step(6);
    cfg_en = 1'b1;
    step(300);
    check(ovf_err == 1'b1, "R7 overflow set", int'(ovf_err), 1);
    check(count == 255, "R7 count saturates", int'(count), 255);

    // R8: disable clears status, keeps captures
    cfg_en = 1'b0;
    step(1);
    check(ovf_err == 1'b0 && count == 0, "R8 disable clears", int'(count), 0);
    check(cap_period == 12, "R8 captures kept", int'(cap_period), 12);
    start(0, 0, 10, 10);
    step(5);
    check(pin_out == 1'b1, "R2 full duty high", int'(pin_out), 1);
    cfg_en = 1'b0;
    step(1);
    check(pin_out == 1'b0 && pin_oe == 1'b0, "R8 pin low when off", int'(pin_out), 0);
    start(3, 0, 10, 10);
    step(10);
    check(count == 0 && pin_out == 1'b0, "R8 idle mode holds", int'(count), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule